// File: doc/BRIEF.md
# Time-Sliced Dual-Channel SDRAM Access Sequencer

This block is the core access engine of an SDRAM controller that two client channels share. It runs an endless loop with a fixed order of three slots: an auto-refresh slot, a slot for channel 0 and a slot for channel 1. The refresh slot runs on every pass. A channel slot runs only when that channel has a request pending at the moment its turn comes up. If it has none, control falls through to the next slot in the same cycle.

Each serviced access moves one data word. The sequence is a bank/row activate, a gap for the activate-to-column delay, then a single column read or write with auto-precharge, then a fixed tail of idle cycles. The tail covers the CAS latency and the precharge recovery. Write data is put on the DQ bus for the column-command cycle only. Read data is captured into that channel's own output register.

A one-cycle "taken" pulse tells the channel front end that its request was accepted, so it can withdraw the request. A one-cycle "done" pulse marks the end of the access, and at that point read data is already valid. Power-up initialisation and clock-domain synchronisation of requests sit outside this block.

Top module: `sdram_slot_arbiter`

## Requirements
- R1: `cmd_o` carries {chip select, row strobe, column strobe, write enable}, all active low. NOP is 4'b0111, ACTIVATE is 4'b0011, READ is 4'b0101, WRITE is 4'b0100 and AUTO-REFRESH is 4'b0001. Every cycle that issues no command shows NOP.
- R2: A refresh slot lasts REF_CYC cycles. Its first cycle issues AUTO-REFRESH and the remaining cycles are NOP. With no requests pending, refresh slots follow one another, so AUTO-REFRESH appears exactly every REF_CYC cycles.
- R3: A request is sampled in the last cycle of a refresh slot. If channel 0 is pending, its ACTIVATE follows in the next cycle. If only channel 1 is pending, channel 1's ACTIVATE follows in the next cycle. If both are pending, channel 0 goes first.
- R4: In the cycle after channel 0's access ends, channel 1's ACTIVATE appears if channel 1 is pending, and AUTO-REFRESH appears otherwise. The cycle after channel 1's access ends always shows AUTO-REFRESH.
- R5: A channel address is {bank, row, column}, with the column in the low COL_W bits. An access issues:
  - ACTIVATE with `ba_o` set to the bank and `a_o` set to the row;
  - then TRCD-1 NOP cycles;
  - then one READ or WRITE with `a_o[10]` = 1 (auto-precharge) and the column in `a_o[COL_W-1:0]`;
  - then TAIL_CYC NOP cycles.
- R6: `taken_o[c]` is high for exactly one cycle, the ACTIVATE cycle of channel c's access. At most one bit of `taken_o` is set at a time.
- R7: `done_o[c]` is a one-cycle pulse in the last tail cycle of channel c's access. It is followed by ACTIVATE or AUTO-REFRESH.
- R8: `dq_oe_o` is high only in a WRITE cycle, and in that cycle `dq_o` carries the write data latched from the channel. In every other cycle the bus is released.
- R9: For a read, `dq_i` is captured CAS_LAT cycles after the READ cycle into the requesting channel's read register, and it is valid no later than the `done_o` pulse (TAIL_CYC > CAS_LAT). The other channel's read register does not change.
- R10: If a front end withdraws its request after `taken_o`, the request is never held pending for more than REF_CYC + TRCD + 1 + TAIL_CYC cycles before it is taken.
- R11: While `rst_n` is low, `taken_o`, `done_o` and `dq_oe_o` are low and both read registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 2 | Pending request per channel (bit c = channel c) |
| wr_i | input | 2 | Per channel: 1 = write, 0 = read |
| addr0_i | input | BANK_W+ROW_W+COL_W | Channel 0 address {bank,row,column} |
| addr1_i | input | BANK_W+ROW_W+COL_W | Channel 1 address {bank,row,column} |
| wdata0_i | input | DATA_W | Channel 0 write data |
| wdata1_i | input | DATA_W | Channel 1 write data |
| taken_o | output | 2 | Request accepted pulse per channel |
| done_o | output | 2 | Access complete pulse per channel |
| rdata0_o | output | DATA_W | Channel 0 read register |
| rdata1_o | output | DATA_W | Channel 1 read register |
| cmd_o | output | 4 | SDRAM command {cs_n,ras_n,cas_n,we_n} |
| ba_o | output | BANK_W | SDRAM bank address |
| a_o | output | ROW_W | SDRAM address bus |
| dq_o | output | DATA_W | Write data to DQ |
| dq_oe_o | output | 1 | DQ output enable |
| dq_i | input | DATA_W | Read data from DQ |

## Verification
The bench builds the block with one bank bit, eleven row bits (the fewest that still hold the auto-precharge bit), four column bits, a three-cycle refresh slot and a three-cycle tail. At that size a behavioural memory of 256 words covers every bank, column and low row value. Every location is written through both channels, with both channels pending in the same loop, and is then read back through the opposite channel. This exercises the slot order, the fall-through from channel 0 to channel 1, the timing of the per-channel capture and the command timing on each access. The short refresh slot keeps the wait bound small enough to check after every grant.

// File: rtl/sdram_arb_pkg.sv
package sdram_arb_pkg;

  // SDRAM command word: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_REF = 4'b0001
  } sdcmd_e;

  typedef enum logic [2:0] {
    ST_REF  = 3'd0,
    ST_ACT  = 3'd1,
    ST_RCD  = 3'd2,
    ST_RW   = 3'd3,
    ST_TAIL = 3'd4
  } slot_e;

  // Address bit that requests auto-precharge on a column command
  localparam int AP_BIT = 10;

endpackage

// File: rtl/sdram_slot_seq.sv
module sdram_slot_seq
  import sdram_arb_pkg::*;
#(
  parameter int REF_CYC  = 6,
  parameter int TRCD     = 2,
  parameter int TAIL_CYC = 4,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       req_i,
  output slot_e            st_o,
  output logic             cur_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             load_ch_o
);

  localparam logic [CNT_W-1:0] REF_LAST  = CNT_W'(REF_CYC - 1);
  localparam logic [CNT_W-1:0] RCD_LAST  = CNT_W'(TRCD - 2);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);

  slot_e            st_q, st_d;
  logic             cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // next-state process
  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      ST_REF: begin
        if (cnt_q == REF_LAST) begin
          cnt_d = '0;
          if (req_i[0]) begin
            st_d  = ST_ACT;
            cur_d = 1'b0;
          end else if (req_i[1]) begin
            st_d  = ST_ACT;
            cur_d = 1'b1;
          end
        end
      end
      ST_ACT: begin
        cnt_d = '0;
        st_d  = (TRCD > 1) ? ST_RCD : ST_RW;
      end
      ST_RCD: begin
        if (cnt_q == RCD_LAST) begin
          cnt_d = '0;
          st_d  = ST_RW;
        end
      end
      ST_RW: begin
        cnt_d = '0;
        st_d  = ST_TAIL;
      end
      ST_TAIL: begin
        if (cnt_q == TAIL_LAST) begin
          cnt_d = '0;
          if (!cur_q && req_i[1]) begin
            st_d  = ST_ACT;
            cur_d = 1'b1;
          end else begin
            st_d  = ST_REF;
          end
        end
      end
      default: begin
        st_d  = ST_REF;
        cnt_d = '0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_REF;
      cur_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o      = st_q;
  assign cur_o     = cur_q;
  assign cnt_o     = cnt_q;
  assign load_o    = (st_d == ST_ACT);
  assign load_ch_o = cur_d;

endmodule

// File: rtl/sdram_req_latch.sv
module sdram_req_latch #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 8,
  localparam int AW    = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              load_ch_i,
  input  logic [1:0]        wr_i,
  input  logic [AW-1:0]     addr0_i,
  input  logic [AW-1:0]     addr1_i,
  input  logic [DATA_W-1:0] wdata0_i,
  input  logic [DATA_W-1:0] wdata1_i,
  output logic              we_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [DATA_W-1:0] wdata_o
);

  logic [AW-1:0]     sel_addr;
  logic [DATA_W-1:0] sel_data;
  logic              sel_we;

  always_comb begin
    sel_addr = load_ch_i ? addr1_i  : addr0_i;
    sel_data = load_ch_i ? wdata1_i : wdata0_i;
    sel_we   = wr_i[load_ch_i];
  end

  // preload on grant; clock enable = load_i
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o    <= 1'b0;
      bank_o  <= '0;
      row_o   <= '0;
      col_o   <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      we_o    <= sel_we;
      bank_o  <= sel_addr[AW-1 -: BANK_W];
      row_o   <= sel_addr[COL_W +: ROW_W];
      col_o   <= sel_addr[COL_W-1:0];
      wdata_o <= sel_data;
    end
  end

endmodule

// File: rtl/sdram_pin_decode.sv
module sdram_pin_decode
  import sdram_arb_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  parameter int CAS_LAT  = 2,
  parameter int TAIL_CYC = 4
) (
  input  slot_e             st_i,
  input  logic              cur_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [1:0]        taken_o,
  output logic [1:0]        done_o,
  output logic              cap_o
);

  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] CAP_CNT   = CNT_W'(CAS_LAT - 1);

  logic [ROW_W-1:0] col_word;
  logic             last_tail;

  always_comb begin
    col_word                = '0;
    col_word[COL_W-1:0]     = col_i;
    col_word[AP_BIT]        = 1'b1;
  end

  always_comb begin
    cmd_o   = CMD_NOP;
    a_o     = '0;
    dq_oe_o = 1'b0;
    unique case (st_i)
      ST_REF:  if (cnt_i == '0) cmd_o = CMD_REF;
      ST_ACT: begin
        cmd_o = CMD_ACT;
        a_o   = row_i;
      end
      ST_RW: begin
        cmd_o   = we_i ? CMD_WR : CMD_RD;
        a_o     = col_word;
        dq_oe_o = we_i;
      end
      default: ;
    endcase
  end

  assign ba_o      = bank_i;
  assign dq_o      = dq_oe_o ? wdata_i : '0;
  assign last_tail = (st_i == ST_TAIL) && (cnt_i == TAIL_LAST);
  assign cap_o     = (st_i == ST_TAIL) && (cnt_i == CAP_CNT) && !we_i;

  for (genvar c = 0; c < 2; c++) begin : g_flag
    assign taken_o[c] = (st_i == ST_ACT) && (cur_i == 1'(c));
    assign done_o[c]  = last_tail && (cur_i == 1'(c));
  end

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_i,
  input  logic                   cur_i,
  input  logic [DATA_W-1:0]      dq_i,
  output logic [1:0][DATA_W-1:0] rdata_o
);

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic cap_en;
    assign cap_en = cap_i && (cur_i == 1'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_o[c] <= '0;
      else if (cap_en) rdata_o[c] <= dq_i;
    end
  end

endmodule

// File: rtl/sdram_slot_arbiter.sv
module sdram_slot_arbiter
  import sdram_arb_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 8,
  parameter int REF_CYC  = 6,
  parameter int TRCD     = 2,
  parameter int CAS_LAT  = 2,
  parameter int TAIL_CYC = 4,
  localparam int AW      = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_i,
  input  logic [1:0]        wr_i,
  input  logic [AW-1:0]     addr0_i,
  input  logic [AW-1:0]     addr1_i,
  input  logic [DATA_W-1:0] wdata0_i,
  input  logic [DATA_W-1:0] wdata1_i,
  output logic [1:0]        taken_o,
  output logic [1:0]        done_o,
  output logic [DATA_W-1:0] rdata0_o,
  output logic [DATA_W-1:0] rdata1_o,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);

  localparam int CNT_W = $clog2(REF_CYC + TRCD + TAIL_CYC + 1);

  slot_e                  st;
  logic                   cur;
  logic [CNT_W-1:0]       cnt;
  logic                   load, load_ch;
  logic                   we_q;
  logic [BANK_W-1:0]      bank_q;
  logic [ROW_W-1:0]       row_q;
  logic [COL_W-1:0]       col_q;
  logic [DATA_W-1:0]      wdata_q;
  logic                   cap;
  logic [1:0][DATA_W-1:0] rdata;

  sdram_slot_seq #(
    .REF_CYC(REF_CYC), .TRCD(TRCD), .TAIL_CYC(TAIL_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .st_o(st), .cur_o(cur), .cnt_o(cnt),
    .load_o(load), .load_ch_o(load_ch)
  );

  sdram_req_latch #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_ch_i(load_ch),
    .wr_i(wr_i), .addr0_i(addr0_i), .addr1_i(addr1_i),
    .wdata0_i(wdata0_i), .wdata1_i(wdata1_i),
    .we_o(we_q), .bank_o(bank_q), .row_o(row_q), .col_o(col_q),
    .wdata_o(wdata_q)
  );

  sdram_pin_decode #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .CAS_LAT(CAS_LAT), .TAIL_CYC(TAIL_CYC)
  ) u_pins (
    .st_i(st), .cur_i(cur), .cnt_i(cnt), .we_i(we_q),
    .bank_i(bank_q), .row_i(row_q), .col_i(col_q), .wdata_i(wdata_q),
    .cmd_o(cmd_o), .ba_o(ba_o), .a_o(a_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .taken_o(taken_o), .done_o(done_o), .cap_o(cap)
  );

  sdram_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .cur_i(cur),
    .dq_i(dq_i), .rdata_o(rdata)
  );

  assign rdata0_o = rdata[0];
  assign rdata1_o = rdata[1];

endmodule

// File: rtl/sdram_slot_arbiter_chk.sv
module sdram_slot_arbiter_chk
  import sdram_arb_pkg::*;
#(
  parameter int REF_CYC  = 6,
  parameter int TRCD     = 2,
  parameter int TAIL_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_i,
  input logic [1:0] taken_o,
  input logic [1:0] done_o,
  input logic [3:0] cmd_o,
  input logic       ap_i,
  input logic       dq_oe_o
);

  localparam int LIMIT = REF_CYC + TRCD + 1 + TAIL_CYC;
  localparam int WC_W  = $clog2(LIMIT + 2) + 1;

  logic [1:0][WC_W-1:0] wait_q;

  for (genvar c = 0; c < 2; c++) begin : g_wait
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         wait_q[c] <= '0;
      else if (req_i[c] && !taken_o[c]) begin
        if (wait_q[c] != '1)              wait_q[c] <= wait_q[c] + 1'b1;
      end else                            wait_q[c] <= '0;
    end

    assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q[c] <= WC_W'(LIMIT));
  end

  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken_o));

  assert_grant_on_activate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|taken_o) |-> (cmd_o == CMD_ACT));

  assert_grant_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|taken_o) |=> !(|taken_o));

  assert_bus_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> (cmd_o == CMD_WR));

  assert_autoprecharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == CMD_RD) || (cmd_o == CMD_WR)) |-> ap_i);

  assert_refresh_then_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REF) |=> (cmd_o == CMD_NOP));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |=> !(|done_o));

  assert_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |=> ((cmd_o == CMD_ACT) || (cmd_o == CMD_REF)));

  assert_ch1_then_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o[1] |=> (cmd_o == CMD_REF));

endmodule

bind sdram_slot_arbiter sdram_slot_arbiter_chk #(
  .REF_CYC(REF_CYC), .TRCD(TRCD), .TAIL_CYC(TAIL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .taken_o(taken_o),
  .done_o(done_o), .cmd_o(cmd_o), .ap_i(a_o[sdram_arb_pkg::AP_BIT]),
  .dq_oe_o(dq_oe_o)
);

// File: tb/sdram_slot_arbiter_test.sv
`timescale 1ns/1ps
module sdram_slot_arbiter_test;
  import sdram_arb_pkg::*;

  localparam int BANK_W = 1, ROW_W = 11, COL_W = 4, DATA_W = 8;
  localparam int REF_CYC = 3, TRCD = 2, CAS_LAT = 2, TAIL_CYC = 3;
  localparam int AW  = BANK_W + ROW_W + COL_W;
  localparam int ACC = TRCD + 1 + TAIL_CYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] req = '0, wr = '0;
  logic [AW-1:0] addr0 = '0, addr1 = '0;
  logic [DATA_W-1:0] wdata0 = '0, wdata1 = '0;
  logic [1:0] taken, done;
  logic [DATA_W-1:0] rdata0, rdata1, dq_o, dq_in;
  logic [3:0] cmd;
  logic [BANK_W-1:0] ba;
  logic [ROW_W-1:0] a;
  logic dq_oe;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int req_t [2];
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_slot_arbiter #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .REF_CYC(REF_CYC), .TRCD(TRCD), .CAS_LAT(CAS_LAT), .TAIL_CYC(TAIL_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr),
    .addr0_i(addr0), .addr1_i(addr1), .wdata0_i(wdata0), .wdata1_i(wdata1),
    .taken_o(taken), .done_o(done), .rdata0_o(rdata0), .rdata1_o(rdata1),
    .cmd_o(cmd), .ba_o(ba), .a_o(a), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  // behavioural SDRAM stub: 256 words, CAS latency 2
  logic [7:0] mem [256];
  logic [2:0] open_row [2];
  logic p0 = 1'b0, p1 = 1'b0;
  logic [7:0] d0, d1;
  assign dq_in = p1 ? d1 : 8'hA5;

  always @(posedge clk) begin
    if (cmd == CMD_ACT) open_row[ba] <= a[2:0];
    if (cmd == CMD_WR)  mem[{ba, open_row[ba], a[3:0]}] <= dq_o;
    p0 <= (cmd == CMD_RD);
    d0 <= mem[{ba, open_row[ba], a[3:0]}];
    p1 <= p0;
    d1 <= d0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int i);
    logic [AW-1:0] r;
    r = '0;
    r[COL_W-1:0] = 4'(i);
    r[COL_W +: 3] = 3'(i >> 4);
    r[AW-1] = 1'((i >> 7) & 1);
    return r;
  endfunction

  function automatic logic [7:0] f(input int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  task automatic set_req(input int ch, input bit we_, input logic [AW-1:0] ad,
                         input logic [7:0] d);
    req[ch] = 1'b1;
    wr[ch]  = we_;
    if (ch == 1) begin addr1 = ad; wdata1 = d; end
    else         begin addr0 = ad; wdata0 = d; end
    req_t[ch] = cyc;
  endtask

  task automatic serve(input int ch, input bit imm, input bit we_,
                       input logic [AW-1:0] ad, input logic [7:0] d);
    int waited;
    logic [7:0] other;
    logic [3:0] exp_cmd;
    waited = 0;
    do begin @(negedge clk); waited++; end while (taken == 2'b00 && waited < 64);
    if (imm) chk(waited == 1, "R4 channel 1 slot follows at once", waited, 1);
    chk(taken == 2'(1 << ch), "R3/R6 grant goes to expected channel", int'(taken), 1 << ch);
    chk(cyc - req_t[ch] <= REF_CYC + ACC + 1, "R10 wait bound", cyc - req_t[ch], REF_CYC + ACC + 1);
    chk(cmd == CMD_ACT, "R5 activate command", int'(cmd), int'(CMD_ACT));
    chk(ba == ad[AW-1], "R5 bank on activate", int'(ba), int'(ad[AW-1]));
    chk(a == ad[COL_W +: ROW_W], "R5 row on activate", int'(a), int'(ad[COL_W +: ROW_W]));
    other = (ch == 1) ? rdata0 : rdata1;
    req[ch] = 1'b0;
    for (int i = 0; i < TRCD - 1; i++) begin
      @(negedge clk);
      chk(cmd == CMD_NOP, "R5 activate-to-column gap", int'(cmd), int'(CMD_NOP));
      chk(taken == 2'b00, "R6 grant lasts one cycle", int'(taken), 0);
    end
    @(negedge clk);
    exp_cmd = we_ ? CMD_WR : CMD_RD;
    chk(cmd == exp_cmd, "R5 column command", int'(cmd), int'(exp_cmd));
    chk(a[10] == 1'b1, "R5 auto-precharge bit", int'(a[10]), 1);
    chk(a[COL_W-1:0] == ad[COL_W-1:0], "R5 column", int'(a[COL_W-1:0]), int'(ad[COL_W-1:0]));
    chk(dq_oe == we_, "R8 bus enable on column cycle", int'(dq_oe), int'(we_));
    if (we_) chk(dq_o == d, "R8 write data on bus", int'(dq_o), int'(d));
    for (int i = 0; i < TAIL_CYC; i++) begin
      @(negedge clk);
      chk(cmd == CMD_NOP && !dq_oe, "R1/R8 tail is NOP with bus released", int'(cmd), int'(CMD_NOP));
      chk(done == ((i == TAIL_CYC - 1) ? 2'(1 << ch) : 2'b00), "R7 done pulse",
          int'(done), (i == TAIL_CYC - 1) ? (1 << ch) : 0);
    end
    if (!we_) chk(((ch == 1) ? rdata1 : rdata0) == d, "R9 read data at done",
                  int'((ch == 1) ? rdata1 : rdata0), int'(d));
    chk(((ch == 1) ? rdata0 : rdata1) == other, "R9 other channel unchanged",
        int'((ch == 1) ? rdata0 : rdata1), int'(other));
  endtask

  task automatic expect_refresh(input string tag);
    @(negedge clk);
    chk(cmd == CMD_REF, tag, int'(cmd), int'(CMD_REF));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int last;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(taken == 2'b00, "R11 taken low in reset", int'(taken), 0);
    chk(done == 2'b00, "R11 done low in reset", int'(done), 0);
    chk(dq_oe == 1'b0, "R11 bus released in reset", int'(dq_oe), 0);
    chk(rdata0 == '0 && rdata1 == '0, "R11 read registers cleared", int'(rdata0 | rdata1), 0);
    rst_n = 1'b1;

    // R2/R1: idle loop refreshes every REF_CYC cycles
    last = -1;
    for (int i = 0; i < 8 * REF_CYC; i++) begin
      @(negedge clk);
      if (cmd == CMD_REF) begin
        if (last >= 0) chk(i - last == REF_CYC, "R2 refresh spacing", i - last, REF_CYC);
        last = i;
      end else begin
        chk(cmd == CMD_NOP, "R1 idle cycle is NOP", int'(cmd), int'(CMD_NOP));
      end
    end

    // channel 0 alone
    set_req(0, 1'b1, mk(5), 8'h3C);
    serve(0, 1'b0, 1'b1, mk(5), 8'h3C);
    expect_refresh("R4 refresh after channel 0 when channel 1 idle");

    // channel 1 alone: channel 0 slot falls through
    set_req(1, 1'b1, mk(200), 8'hC3);
    serve(1, 1'b0, 1'b1, mk(200), 8'hC3);
    expect_refresh("R4 refresh after channel 1");

    // exhaustive write sweep, both channels pending in each loop
    for (int k = 0; k < 128; k++) begin
      set_req(0, 1'b1, mk(2 * k), f(2 * k));
      set_req(1, 1'b1, mk(2 * k + 1), f(2 * k + 1));
      serve(0, 1'b0, 1'b1, mk(2 * k), f(2 * k));
      serve(1, 1'b1, 1'b1, mk(2 * k + 1), f(2 * k + 1));
      expect_refresh("R4 refresh closes the loop");
    end

    // read back through the opposite channel
    for (int k = 0; k < 128; k++) begin
      set_req(0, 1'b0, mk(2 * k + 1), 8'h00);
      set_req(1, 1'b0, mk(2 * k), 8'h00);
      serve(0, 1'b0, 1'b0, mk(2 * k + 1), f(2 * k + 1));
      serve(1, 1'b1, 1'b0, mk(2 * k), f(2 * k));
      expect_refresh("R4 refresh after read pair");
    end

    // mixed: channel 0 writes while channel 1 reads
    set_req(0, 1'b1, mk(17), 8'h5A);
    set_req(1, 1'b0, mk(40), 8'h00);
    serve(0, 1'b0, 1'b1, mk(17), 8'h5A);
    serve(1, 1'b1, 1'b0, mk(40), f(40));
    expect_refresh("R4 refresh after mixed pair");
    set_req(1, 1'b0, mk(17), 8'h00);
    serve(1, 1'b0, 1'b0, mk(17), 8'h5A);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule